// File: doc/BRIEF.md
# Serial Transmitter with Line Break Control

This block turns bytes into asynchronous serial frames on a single output line. Bytes enter through a 16-entry queue and leave as 8N1 frames: one low start bit, eight data bits least significant first, one high stop bit. A bit-rate tick from outside the block sets the bit timing, and each bit lasts one tick interval. Frames in the queue go out back to back, with no idle bits between them.

Enable and disable pulses gate the block. While it is disabled, writes to the queue are dropped and both status flags read low. Bytes that were queued before a disable are still sent in full. The ready flag reports room in the queue. The empty flag reports that the queue and the shift stage are both empty.

A break request holds the line low. It takes effect only after every queued byte has left, including bytes written after the request. A release pulse ends the break. After a release, the line is held marking for at least one full bit before the next frame.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset the line output is high (marking) and both the ready and the empty flag are low, since the block starts disabled.
- R2: A queue write is dropped when the block is disabled or the queue already holds FIFO_DEPTH (16) bytes; a dropped byte never appears on the line.
- R3: The ready flag equals "enabled and queue not full", and the empty flag equals "enabled, queue empty and no frame or break in progress"; both update in the clock cycle after the enable pulse.
- R4: Each byte goes out as one low start bit, the data bits least significant first, then one high stop bit, one bit per tick interval, in write order, with consecutive frames adjacent.
- R5: A disable pulse drops both flags in the next cycle, while every byte already queued or shifting is still sent in full. A disable on the same cycle as an enable wins.
- R6: A break request made while the block is disabled is ignored and leaves nothing pending for a later enable.
- R7: With nothing queued or shifting, an accepted break request drives the line low at the next tick, which is within two bit times.
- R8: A break request made while bytes are queued or shifting waits until all of them, including bytes written after the request, have been sent.
- R9: A break release drives the line high in the next clock cycle. The line then stays high for at least one full bit interval before the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Queue write strobe |
| wr_data_i | input | DATA_W | Byte to queue |
| en_i | input | 1 | Enable pulse |
| dis_i | input | 1 | Disable pulse |
| brk_start_i | input | 1 | Break request pulse |
| brk_stop_i | input | 1 | Break release pulse |
| tick_i | input | 1 | One-cycle bit-rate tick |
| txd_o | output | 1 | Serial line output |
| tx_rdy_o | output | 1 | Queue has room (when enabled) |
| tx_emt_o | output | 1 | Queue and shifter empty (when enabled) |

## Verification
The bench uses the default parameters, DATA_W of 8 and FIFO_DEPTH of 16, and raises the tick every fourth clock. With these values, all 256 byte values can be pushed through the line inside the cycle budget. The tick can also be paused, so the bench can fill the queue to exactly 16 entries, attempt a 17th write, and stack bytes before and after a break request. A line decoder in the bench samples once per tick. It recovers bytes, break periods and the marking gap in front of each start bit, and compares them with values the bench computes from the written sequence.

// File: rtl/uart_brk_tx_pkg.sv
package uart_brk_tx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_DATA = 2'd1,
    TX_BRK  = 2'd2,
    TX_MARK = 2'd3
  } tx_state_e;
endpackage

// File: rtl/uart_brk_tx_fifo.sv
module uart_brk_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] cnt_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign cnt_o   = cnt_q;
  assign data_o  = mem_q[rd_ptr_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end
endmodule

// File: rtl/uart_brk_tx_shifter.sv
module uart_brk_tx_shifter
  import uart_brk_tx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         avail_i,
  input  logic [W-1:0] data_i,
  output logic         pop_o,
  input  logic         brk_start_i,
  input  logic         brk_stop_i,
  output logic         txd_o,
  output logic         idle_o
);
  localparam int FW = W + 2;
  localparam int NW = $clog2(FW);

  tx_state_e     state_q;
  logic [FW-1:0] frame_q;
  logic [NW-1:0] bit_q;
  logic          brk_req_q;
  logic          mark_q;
  logic          last_bit;

  assign last_bit = (bit_q == NW'(FW - 1));
  // queued data always beats a pending break
  assign pop_o    = tick_i && avail_i &&
                    ((state_q == TX_IDLE) || (state_q == TX_DATA && last_bit));
  assign txd_o    = (state_q == TX_DATA) ? frame_q[0] : (state_q != TX_BRK);
  assign idle_o   = (state_q == TX_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= TX_IDLE;
      frame_q   <= '1;
      bit_q     <= '0;
      brk_req_q <= 1'b0;
      mark_q    <= 1'b0;
    end else begin
      if (brk_stop_i)       brk_req_q <= 1'b0;
      else if (brk_start_i) brk_req_q <= 1'b1;

      if (pop_o) begin
        state_q <= TX_DATA;
        frame_q <= {1'b1, data_i, 1'b0};
        bit_q   <= '0;
      end else begin
        unique case (state_q)
          TX_IDLE: if (tick_i && brk_req_q && !brk_stop_i) state_q <= TX_BRK;
          TX_DATA: if (tick_i) begin
            if (last_bit) state_q <= (brk_req_q && !brk_stop_i) ? TX_BRK : TX_IDLE;
            else begin
              frame_q <= {1'b1, frame_q[FW-1:1]};
              bit_q   <= bit_q + 1'b1;
            end
          end
          TX_BRK: if (brk_stop_i) begin
            state_q <= TX_MARK;
            mark_q  <= 1'b0;
          end
          // two ticks guarantee one whole bit interval of marking
          TX_MARK: if (tick_i) begin
            if (mark_q) state_q <= TX_IDLE;
            mark_q <= 1'b1;
          end
          default: state_q <= TX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              en_i,
  input  logic              dis_i,
  input  logic              brk_start_i,
  input  logic              brk_stop_i,
  input  logic              tick_i,
  output logic              txd_o,
  output logic              tx_rdy_o,
  output logic              tx_emt_o
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic              enabled_q;
  logic              fifo_empty, fifo_full, pop;
  logic [DATA_W-1:0] head;
  logic [CW-1:0]     fifo_cnt;
  logic              sh_idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    enabled_q <= 1'b0;
    else if (dis_i) enabled_q <= 1'b0;
    else if (en_i)  enabled_q <= 1'b1;
  end

  uart_brk_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_en_i && enabled_q),
    .data_i  (wr_data_i),
    .pop_i   (pop),
    .data_o  (head),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .cnt_o   (fifo_cnt)
  );

  uart_brk_tx_shifter #(.W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .avail_i     (!fifo_empty),
    .data_i      (head),
    .pop_o       (pop),
    .brk_start_i (brk_start_i && enabled_q),
    .brk_stop_i  (brk_stop_i),
    .txd_o       (txd_o),
    .idle_o      (sh_idle)
  );

  assign tx_rdy_o = enabled_q && !fifo_full;
  assign tx_emt_o = enabled_q && fifo_empty && sh_idle;
endmodule

// File: rtl/uart_brk_tx_checker.sv
module uart_brk_tx_checker #(
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          dis_i,
  input logic          brk_stop_i,
  input logic          txd_o,
  input logic          tx_rdy_o,
  input logic          tx_emt_o,
  input logic [CW-1:0] fifo_cnt
);
  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(FIFO_DEPTH)); // R2
  AST_EMT_HAS_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_emt_o |-> tx_rdy_o); // R3
  AST_EMT_LINE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_emt_o |-> txd_o); // R3
  AST_DIS_DROPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> (!tx_rdy_o && !tx_emt_o)); // R5
  AST_LINE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txd_o) |-> ($past(tick_i) || $past(brk_stop_i))); // R4
  AST_RELEASE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_stop_i |=> txd_o); // R9
endmodule

bind uart_brk_tx uart_brk_tx_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .dis_i      (dis_i),
  .brk_stop_i (brk_stop_i),
  .txd_o      (txd_o),
  .tx_rdy_o   (tx_rdy_o),
  .tx_emt_o   (tx_emt_o),
  .fifo_cnt   (fifo_cnt)
);

// File: tb/uart_brk_tx_test.sv
`timescale 1ns/1ps
module uart_brk_tx_test;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, en = 1'b0, dis = 1'b0, brk_start = 1'b0, brk_stop = 1'b0;
  logic tick = 1'b0;
  logic [7:0] wr_data = '0;
  logic txd, rdy, emt;
  logic tick_run = 1'b1;

  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0] rx_q [0:1023];
  int rx_n = 0, brk_n = 0, brk_rx_n = -1, last_high = 0;

  always #4 clk = ~clk;

  uart_brk_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .en_i(en), .dis_i(dis), .brk_start_i(brk_start), .brk_stop_i(brk_stop),
    .tick_i(tick), .txd_o(txd), .tx_rdy_o(rdy), .tx_emt_o(emt)
  );

  // tick source and line decoder, one sample per bit interval
  initial begin
    int div = 0, dst = 0, bn = 0, high_run = 0;
    logic [7:0] sh = '0;
    forever begin
      @(negedge clk);
      if (tick) begin
        case (dst)
          0: if (!txd) begin dst = 1; bn = 0; last_high = high_run; end
             else high_run++;
          1: begin
            if (bn < 8) begin sh[bn] = txd; bn++; end
            else if (txd) begin rx_q[rx_n] = sh; rx_n++; dst = 0; high_run = 0; end
            else begin
              if (brk_rx_n < 0) brk_rx_n = rx_n;
              brk_n++; dst = 2;
            end
          end
          default: if (txd) begin dst = 0; high_run = 1; end
        endcase
      end
      div = (div == DIV - 1) ? 0 : div + 1;
      tick <= tick_run && (div == DIV - 1);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: en = 1'b1; 1: dis = 1'b1; 2: brk_start = 1'b1; default: brk_stop = 1'b1;
    endcase
    @(negedge clk);
    en = 1'b0; dis = 1'b0; brk_start = 1'b0; brk_stop = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    cyc(3);
    // R1 reset state
    chk(txd === 1'b1, "R1 txd", txd, 1);
    chk(rdy === 1'b0, "R1 rdy", rdy, 0);
    chk(emt === 1'b0, "R1 emt", emt, 0);
    rst_n = 1'b1;
    cyc(2);

    // R2 write while disabled is dropped
    put(8'h33);
    pulse(0);
    // R3 flags one cycle after enable
    chk(rdy === 1'b1, "R3 rdy after enable", rdy, 1);
    chk(emt === 1'b1, "R3 emt after enable", emt, 1);
    cyc(20 * DIV);
    chk(rx_n == 0, "R2 disabled write not sent", rx_n, 0);

    // R2 fill to depth, 17th dropped
    tick_run = 1'b0; cyc(2 * DIV);
    for (int k = 0; k < 16; k++) put(8'h10 + 8'(k));
    chk(rdy === 1'b0, "R3 rdy when full", rdy, 0);
    chk(emt === 1'b0, "R3 emt when queued", emt, 0);
    put(8'hEE);
    tick_run = 1'b1;
    cyc(18 * 10 * DIV);
    chk(rx_n == 16, "R2 only depth bytes sent", rx_n, 16);
    for (int k = 0; k < 16; k++)
      chk(rx_q[k] == 8'h10 + 8'(k), "R4 fill order", rx_q[k], 16 + k);
    chk(emt === 1'b1, "R3 emt after drain", emt, 1);

    // R4 all byte values, back to back
    base = rx_n;
    for (int v = 0; v < 256; v++) begin
      while (!rdy) cyc(1);
      put(8'(v));
    end
    while (!emt) cyc(1);
    cyc(2 * DIV);
    chk(rx_n == base + 256, "R4 sweep count", rx_n - base, 256);
    for (int v = 0; v < 256; v++)
      chk(rx_q[base + v] == 8'(v), "R4 sweep value", rx_q[base + v], v);
    chk(last_high == 0, "R4 frames adjacent", last_high, 0);

    // R5 disable drains queue
    base = rx_n;
    tick_run = 1'b0; cyc(2 * DIV);
    for (int k = 0; k < 5; k++) put(8'hC0 ^ 8'(k * 7));
    pulse(1);
    chk(rdy === 1'b0, "R5 rdy after disable", rdy, 0);
    chk(emt === 1'b0, "R5 emt after disable", emt, 0);
    put(8'h99);
    tick_run = 1'b1;
    cyc(8 * 10 * DIV);
    chk(rx_n == base + 5, "R5 drained count", rx_n - base, 5);
    for (int k = 0; k < 5; k++)
      chk(rx_q[base + k] == (8'hC0 ^ 8'(k * 7)), "R5 drained value", rx_q[base + k], 192 ^ (k * 7));

    // R6 break request while disabled
    pulse(2);
    cyc(4 * DIV);
    chk(txd === 1'b1, "R6 break ignored while disabled", txd, 1);
    pulse(0);
    cyc(4 * DIV);
    chk(txd === 1'b1, "R6 nothing pending after enable", txd, 1);

    // R7 break on empty transmitter
    pulse(2);
    cyc(2 * DIV);
    chk(txd === 1'b0, "R7 break within two bits", txd, 0);
    cyc(12 * DIV);
    chk(txd === 1'b0, "R7 break held", txd, 0);
    // R9 release and marking gap
    base = rx_n;
    pulse(3);
    chk(txd === 1'b1, "R9 line high after release", txd, 1);
    put(8'h5A);
    cyc(14 * DIV);
    chk(rx_n == base + 1 && rx_q[base] == 8'h5A, "R9 byte after break", rx_q[base], 90);
    chk(last_high >= 1, "R9 marking before start", last_high, 1);

    // R8 break waits for queue, including later writes
    base = rx_n; brk_rx_n = -1;
    tick_run = 1'b0; cyc(2 * DIV);
    for (int k = 0; k < 3; k++) put(8'hA1 + 8'(k));
    pulse(2);
    put(8'hA4); put(8'hA5);
    tick_run = 1'b1;
    cyc(6 * 10 * DIV);
    chk(txd === 1'b0, "R8 break after drain", txd, 0);
    chk(rx_n == base + 5, "R8 bytes before break", rx_n - base, 5);
    for (int k = 0; k < 5; k++)
      chk(rx_q[base + k] == 8'hA1 + 8'(k), "R8 byte value", rx_q[base + k], 161 + k);
    cyc(10 * DIV);
    chk(brk_rx_n == base + 5, "R8 break position", brk_rx_n - base, 5);
    pulse(3);
    cyc(4 * DIV);
    chk(txd === 1'b1 && emt === 1'b1, "R9 idle after release", txd, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule